// File: doc/BRIEF.md
# Corrected-Error Threshold Monitor

This block sits beside a memory controller's ECC decoder and watches the status code reported for each completed read. Every access that the decoder reports as repaired, whether one bit or two bits were fixed, adds one to an internal tally. Once the tally goes past a threshold that software supplies, the block raises an interrupt. The interrupt reports corrected errors. It is not a fatal-error signal, and uncorrectable results are not counted.

The interrupt stays high until software writes the control register with its clear bit set. That write also empties the tally. The same control write sets up a self-test injector. While the injector is enabled, it drives a one-hot mask that the data path XORs into every memory reference, so a single-bit error is forced on each access. The decoder should then report each of those accesses as corrected, which exercises the counting path from end to end.

A three-state machine governs the interrupt. QUIET means the tally is zero. TALLY means the tally is non-zero and not above the threshold. ALERT means the interrupt is asserted. The transitions are:
- **first_hit**: QUIET to TALLY, on a counted event that does not exceed the threshold.
- **trip_direct**: QUIET to ALERT, on a counted event that exceeds the threshold (threshold zero).
- **trip**: TALLY to ALERT, when the tally exceeds the threshold. A new event or a lowered threshold can cause this.
- **wipe**: any state to QUIET, on a clear write.

Top module: `cerr_watch`

## Requirements
- R1: An access counts only when `acc_valid` is high and `acc_code` is 2'b01 (one bit fixed) or 2'b10 (two bits fixed). The codes 2'b00 (clean) and 2'b11 (uncorrectable) are ignored, and so is any code presented while `acc_valid` is low.
- R2: `irq` rises on the clock edge that samples the counted access which makes the tally strictly greater than `thresh`. A tally equal to `thresh` leaves `irq` low.
- R3: With `thresh` equal to 0, the first counted access raises `irq` on the edge that samples it.
- R4: Once high, `irq` stays high until a cycle with `ctrl_wr` and `ctrl_clr` both high. That edge drops `irq` and zeroes the tally. A counted access in the same cycle as a clear is discarded.
- R5: The tally saturates at 2^CNT_W-1 and never wraps to a smaller value.
- R6: The injection settings are taken from `ctrl_inj_en` and `ctrl_inj_sel` on each edge where `ctrl_wr` is high. While enabled, `inj_mask` has exactly bit `ctrl_inj_sel` set. A control write without `ctrl_clr` leaves the tally unchanged.
- R7: `inj_mask` is all zeros whenever injection is disabled.
- R8: After reset, `irq` is low, `inj_mask` is zero and the tally is zero.
- R9: If `thresh` is lowered below the current tally, `irq` rises on the next edge without any new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A read result is present this cycle |
| acc_code | input | 2 | Decoder outcome: 00 clean, 01 one bit fixed, 10 two bits fixed, 11 uncorrectable |
| thresh | input | CNT_W | Software threshold; `irq` fires when the tally exceeds it |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_clr | input | 1 | Clear bit: drop `irq` and zero the tally |
| ctrl_inj_en | input | 1 | Injection enable field |
| ctrl_inj_sel | input | $clog2(DATA_W) | Index of the data bit to flip |
| irq | output | 1 | Corrected-error interrupt (level) |
| inj_mask | output | DATA_W | XOR mask applied by the data path on every reference |

## Verification
Every result appears one clock edge after the cycle that causes it. This holds for the `irq` rise, the `irq` drop on clear, and the `inj_mask` update after a control write. No input reaches an output combinationally. The bench applies one stimulus per cycle on the falling edge. After the following rising edge it queues the expected `irq` and `inj_mask`, and the monitor compares them on the next falling edge. Each comparison therefore lands exactly one edge after its stimulus, while the registered outputs are stable. The saturation case uses a 4-bit tally, so the bench can drive more events than the maximum and then detect wrap-around by lowering the threshold.

// File: rtl/cew_pkg.sv
`timescale 1ns/1ps
package cew_pkg;

    // Outcome reported by the ECC decoder for one access.
    typedef enum logic [1:0] {
        ECC_CLEAN = 2'b00,
        ECC_FIX1  = 2'b01,
        ECC_FIX2  = 2'b10,
        ECC_FATAL = 2'b11
    } ecc_code_e;

    // Interrupt state machine.
    typedef enum logic [1:0] {
        MON_QUIET = 2'b00,
        MON_TALLY = 2'b01,
        MON_ALERT = 2'b10
    } mon_state_e;

endpackage

// File: rtl/cew_counter.sv
`timescale 1ns/1ps
// Saturating tally of corrected-error events.
module cew_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             wipe,
    output logic [CNT_W-1:0] cnt_nx
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Clear has priority over a same-cycle event; the top value is sticky.
    always_comb begin
        if (wipe)
            cnt_nx = '0;
        else if (bump && (cnt_q != CMAX))
            cnt_nx = cnt_q + 1'b1;
        else
            cnt_nx = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/cew_fsm.sv
`timescale 1ns/1ps
// Interrupt state machine: QUIET -> TALLY -> ALERT, wiped by a clear write.
module cew_fsm
    import cew_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             wipe,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [CNT_W-1:0] thresh,
    output logic             irq
);
    mon_state_e state_q, state_nx;
    logic       over;

    assign over = (cnt_nx > thresh);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MON_QUIET;
        else
            state_q <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MON_QUIET: begin
                if (wipe)
                    state_nx = MON_QUIET;
                else if (bump && over)
                    state_nx = MON_ALERT;      // trip_direct
                else if (bump)
                    state_nx = MON_TALLY;      // first_hit
            end
            MON_TALLY: begin
                if (wipe)
                    state_nx = MON_QUIET;      // wipe
                else if (over)
                    state_nx = MON_ALERT;      // trip
            end
            MON_ALERT: begin
                if (wipe)
                    state_nx = MON_QUIET;      // wipe
            end
            default: state_nx = MON_QUIET;
        endcase
    end

    // Outputs.
    always_comb begin
        irq = (state_q == MON_ALERT);
    end
endmodule

// File: rtl/cew_inject.sv
`timescale 1ns/1ps
// Self-test injector: one-hot XOR mask for the data path.
module cew_inject #(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              en,
    input  logic [IDX_W-1:0]  sel,
    output logic [DATA_W-1:0] mask
);
    logic             en_q;
    logic [IDX_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr) begin
            en_q  <= en;
            sel_q <= sel;
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask[i] = en_q && (sel_q == IDX_W'(i));
    end
endmodule

// File: rtl/cerr_watch.sv
`timescale 1ns/1ps
// Corrected-error threshold monitor, top level.
module cerr_watch
    import cew_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_code,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              ctrl_wr,
    input  logic              ctrl_clr,
    input  logic              ctrl_inj_en,
    input  logic [IDX_W-1:0]  ctrl_inj_sel,
    output logic              irq,
    output logic [DATA_W-1:0] inj_mask
);
    logic             bump;
    logic             wipe;
    logic [CNT_W-1:0] cnt_nx;

    // Only repaired accesses count; uncorrectable ones go elsewhere.
    assign bump = acc_valid &&
                  ((acc_code == ECC_FIX1) || (acc_code == ECC_FIX2));
    assign wipe = ctrl_wr && ctrl_clr;

    cew_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (bump),
        .wipe   (wipe),
        .cnt_nx (cnt_nx)
    );

    cew_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (bump),
        .wipe   (wipe),
        .cnt_nx (cnt_nx),
        .thresh (thresh),
        .irq    (irq)
    );

    cew_inject #(.DATA_W(DATA_W)) u_inj (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .en    (ctrl_inj_en),
        .sel   (ctrl_inj_sel),
        .mask  (inj_mask)
    );
endmodule

// File: rtl/cew_chk.sv
`timescale 1ns/1ps
module cew_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_code,
    input logic [CNT_W-1:0]  thresh,
    input logic              ctrl_wr,
    input logic              ctrl_clr,
    input logic              ctrl_inj_en,
    input logic              irq,
    input logic [DATA_W-1:0] inj_mask
);
    logic clr_w;
    logic hit;
    assign clr_w = ctrl_wr && ctrl_clr;
    assign hit   = acc_valid && ((acc_code == 2'b01) || (acc_code == 2'b10));

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_w |=> irq);

    // R4
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> !irq);

    // R3
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) && hit && !clr_w |=> irq);

    // R6
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_mask));

    // R6
    mask_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_inj_en |=> $countones(inj_mask) == 1);

    // R7
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !ctrl_inj_en |=> inj_mask == '0);
endmodule

bind cerr_watch cew_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_code    (acc_code),
    .thresh      (thresh),
    .ctrl_wr     (ctrl_wr),
    .ctrl_clr    (ctrl_clr),
    .ctrl_inj_en (ctrl_inj_en),
    .irq         (irq),
    .inj_mask    (inj_mask)
);

// File: tb/tb_cerr_watch.sv
`timescale 1ns/1ps
module tb_cerr_watch;
    localparam int DW   = 64;
    localparam int CW   = 4;
    localparam int IW   = $clog2(DW);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_code = 2'b00;
    logic [CW-1:0] thresh = '0;
    logic          ctrl_wr = 1'b0;
    logic          ctrl_clr = 1'b0;
    logic          ctrl_inj_en = 1'b0;
    logic [IW-1:0] ctrl_inj_sel = '0;
    logic          irq;
    logic [DW-1:0] inj_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state, from the requirements.
    int          m_cnt = 0;
    logic        m_irq = 1'b0;
    logic        m_en = 1'b0;
    int          m_sel = 0;

    logic        q_irq[$];
    logic [DW-1:0] q_mask[$];
    string       q_tag[$];

    cerr_watch #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_code(acc_code),
        .thresh(thresh), .ctrl_wr(ctrl_wr), .ctrl_clr(ctrl_clr),
        .ctrl_inj_en(ctrl_inj_en), .ctrl_inj_sel(ctrl_inj_sel),
        .irq(irq), .inj_mask(inj_mask)
    );

    always #2.5 clk = ~clk;

    // Driver: one stimulus per cycle; expected item queued after the edge.
    task automatic step(input logic v, input logic [1:0] c, input int thr,
                        input logic w, input logic cl, input logic e,
                        input int s, input string tag);
        logic [DW-1:0] em;
        @(negedge clk);
        acc_valid = v; acc_code = c; thresh = CW'(thr);
        ctrl_wr = w; ctrl_clr = cl; ctrl_inj_en = e; ctrl_inj_sel = IW'(s);
        if (w && cl) begin
            m_cnt = 0;
            m_irq = 1'b0;
        end else begin
            if (v && (c == 2'b01 || c == 2'b10) && m_cnt < CMAX) m_cnt++;
            if (m_cnt > thr) m_irq = 1'b1;
        end
        if (w) begin
            m_en = e;
            m_sel = s;
        end
        em = m_en ? (DW'(1) << m_sel) : '0;
        @(posedge clk);
        #1;
        q_irq.push_back(m_irq);
        q_mask.push_back(em);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int thr, input string tag);
        step(1'b0, 2'b00, thr, 1'b0, 1'b0, 1'b0, 0, tag);
    endtask

    task automatic hit(input logic [1:0] c, input int thr, input string tag);
        step(1'b1, c, thr, 1'b0, 1'b0, 1'b0, 0, tag);
    endtask

    task automatic clear(input int thr, input string tag);
        step(1'b0, 2'b00, thr, 1'b1, 1'b1, m_en, m_sel, tag);
    endtask

    // Monitor: compare at the falling edge after each result is due.
    initial begin
        forever begin
            @(negedge clk);
            if (q_irq.size() > 0) begin
                logic ei;
                logic [DW-1:0] em;
                string t;
                ei = q_irq.pop_front();
                em = q_mask.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (irq !== ei) begin
                    errors++;
                    $display("FAIL %s irq: actual %b expected %b", t, irq, ei);
                end
                checks++;
                if (inj_mask !== em) begin
                    errors++;
                    $display("FAIL %s inj_mask: actual %h expected %h", t, inj_mask, em);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (irq !== 1'b0 || inj_mask !== '0) begin
            errors++;
            $display("FAIL R8 reset: actual irq=%b mask=%h expected 0/0", irq, inj_mask);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R8: quiet after reset release
        idle(3, "R8");
        // R2: three events equal to threshold 3 keep irq low
        hit(2'b01, 3, "R2");
        hit(2'b10, 3, "R2");
        hit(2'b01, 3, "R2");
        // R1: clean, uncorrectable and unqualified codes are ignored
        hit(2'b00, 3, "R1");
        hit(2'b11, 3, "R1");
        step(1'b0, 2'b01, 3, 1'b0, 1'b0, 1'b0, 0, "R1");
        step(1'b0, 2'b10, 3, 1'b0, 1'b0, 1'b0, 0, "R1");
        // R2: fourth counted event exceeds 3
        hit(2'b10, 3, "R2");
        // R4: held with no clear
        idle(3, "R4");
        idle(3, "R4");
        hit(2'b11, 3, "R4");
        clear(3, "R4");
        idle(3, "R4");
        // R4: event in the same cycle as clear is discarded
        step(1'b1, 2'b01, 0, 1'b1, 1'b1, 1'b0, 0, "R4");
        idle(0, "R4");
        // R3: threshold zero fires on first event
        hit(2'b01, 0, "R3");
        clear(0, "R3");
        hit(2'b10, 0, "R3");
        clear(2, "R3");
        // R6: control write without clear keeps the tally
        hit(2'b01, 2, "R6");
        hit(2'b01, 2, "R6");
        step(1'b0, 2'b00, 2, 1'b1, 1'b0, 1'b1, 5, "R6");
        idle(2, "R6");
        hit(2'b10, 2, "R6");
        step(1'b0, 2'b00, 2, 1'b1, 1'b0, 1'b1, 63, "R6");
        step(1'b1, 2'b01, 2, 1'b1, 1'b0, 1'b1, 0, "R6");
        // R7: disabling zeroes the mask even with a selector given
        step(1'b0, 2'b00, 2, 1'b1, 1'b0, 1'b0, 7, "R7");
        idle(2, "R7");
        // Clear together with an injection change
        step(1'b0, 2'b00, CMAX, 1'b1, 1'b1, 1'b1, 33, "R6");
        // R5: saturate at maximum, threshold at maximum never trips
        for (int i = 0; i < CMAX + 6; i++) hit(2'b01, CMAX, "R5");
        idle(CMAX, "R5");
        // R9 / R5: lowering threshold below a saturated tally trips
        idle(CMAX - 1, "R9");
        idle(CMAX - 1, "R5");
        clear(CMAX, "R9");
        hit(2'b01, CMAX, "R9");
        hit(2'b01, CMAX, "R9");
        idle(1, "R9");
        step(1'b0, 2'b00, 1, 1'b1, 1'b1, 1'b0, 0, "R7");
        idle(1, "R7");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule